// File: doc/BRIEF.md
# Error-Tolerant Wake Pattern Correlator

This block watches the sliced data bit of one low-frequency receive channel and decides when a fixed wake pattern has arrived. It recovers half-bit timing from a 32.768 kHz oscillator clock by counting twelve clocks per half-bit. It realigns that count on every data transition and samples each half-bit in its middle. The last sixteen samples form a sliding window. Each time a sample enters the window, the window is scored against the pattern.

The pattern is the Manchester expansion of the byte 0x96. The scoring is asymmetric. Every position where the pattern holds a one must be received as a one. A selectable number of positions where the pattern holds a zero may arrive wrong. The correlator wakes on the first data transition and idles itself when the line has been quiet too long. It can also be cleared, disabled or frozen from outside.

Top module: `wake_correlator`

## Requirements
- R1: While active, the block samples `data_i` once per half-bit of 12 clock cycles. It takes the sample at the sixth rising edge after the last data transition and restarts the 12-cycle count on every transition.
- R2: The pattern is 16'h9669, compared with the first received half-bit in bit 15. This is byte 0x96, MSB first, with a Manchester one sent as 1 then 0 and a zero as 0 then 1. A match needs 16 samples taken since the block last became active.
- R3: `tol_sel_i` gives the number of pattern-zero positions that may be received as one: 2'b00 allows 3, 2'b10 allows 2, 2'b01 allows 1 and 2'b11 allows 0. The register that drives it powers up at 2'b01.
- R4: A window with any pattern-one position received as zero never matches, whatever the tolerance.
- R5: An alternating 1010… preamble of any length never produces a match, whatever the tolerance.
- R6: A match raises `match_o` for exactly one cycle: the cycle after the edge that takes the sixteenth matching sample. That is six edges after the edge that detects the transition opening the last half-bit.
- R7: `active_o` rises on the edge that detects the first data transition. It falls after 108 consecutive cycles with no transition, and at that point the sample history is emptied.
- R8: `corr_clr_i` high at an edge makes the block idle with an empty history and no pulse. This holds even when the same edge would take a sample.
- R9: `corr_off_i` high, with the block enabled and not being cleared, freezes all state: there are no pulses and no timeout. Operation resumes when it is released.
- R10: `en_i` low keeps the block idle and empty, with no pulses.
- R11: During and directly after reset, `match_o` and `active_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; low holds the block idle |
| corr_clr_i | input | 1 | Synchronous correlator clear |
| corr_off_i | input | 1 | Freeze all correlator state |
| tol_sel_i | input | 2 | Zero-error tolerance select |
| data_i | input | 1 | Sliced half-bit data from the detector |
| match_o | output | 1 | One-cycle wake pattern detected pulse |
| active_o | output | 1 | High while the correlator is active |

## Verification
The synchronous clear and the mid-half-bit sample that completes a valid pattern can fall on the same clock edge. The bench sends a preamble and fifteen correct half-bits, then opens the last half-bit with a transition. It raises the clear for exactly the sixth edge after that transition, which is the sampling edge. The result is judged correct only if no pulse ever appears and the status reads idle on the next cycle.

// File: rtl/wkc_pkg.sv
`timescale 1ns/1ps
package wkc_pkg;

    // Tolerated number of wrong zero positions for each select code.
    function automatic int unsigned tol_limit(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3;
            2'b10:   return 2;
            2'b01:   return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/wkc_halfbit_timer.sv
`timescale 1ns/1ps
module wkc_halfbit_timer #(
    parameter int CLK_PER_HB = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic hold_i,
    input  logic edge_i,
    output logic tick_o
);
    localparam int CNT_W     = $clog2(CLK_PER_HB);
    localparam int SAMPLE_AT = CLK_PER_HB / 2 - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (!hold_i) begin
            if (edge_i || s_q.cnt == CNT_W'(CLK_PER_HB - 1))
                s_d.cnt = '0;
            else
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tick_o = !clear_i && !hold_i && (s_q.cnt == CNT_W'(SAMPLE_AT));
endmodule

// File: rtl/wkc_activity.sv
`timescale 1ns/1ps
module wkc_activity #(
    parameter int IDLE_LIMIT = 108
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic hold_i,
    input  logic edge_i,
    output logic active_o,
    output logic expire_o
);
    localparam int IDLE_W = $clog2(IDLE_LIMIT);

    typedef struct packed {
        logic              active;
        logic [IDLE_W-1:0] idle;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (clear_i) begin
            s_d = '0;
        end else if (!hold_i) begin
            if (edge_i) begin
                s_d.active = 1'b1;
                s_d.idle   = '0;
            end else if (s_q.active) begin
                if (s_q.idle == IDLE_W'(IDLE_LIMIT - 1)) begin
                    s_d.active = 1'b0;
                    s_d.idle   = '0;
                    expire_o   = 1'b1;
                end else begin
                    s_d.idle = s_q.idle + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign active_o = s_q.active;
endmodule

// File: rtl/wkc_pattern_scorer.sv
`timescale 1ns/1ps
module wkc_pattern_scorer
    import wkc_pkg::*;
#(
    parameter int                 PAT_LEN = 16,
    parameter logic [PAT_LEN-1:0] PAT     = 16'h9669
) (
    input  logic [PAT_LEN-1:0] window_i,
    input  logic [1:0]         tol_sel_i,
    output logic               hit_o
);
    localparam int ERR_W = $clog2(PAT_LEN + 1);

    logic             ones_missing;
    logic [ERR_W-1:0] zero_errs;

    always_comb begin
        ones_missing = 1'b0;
        zero_errs    = '0;
        for (int i = 0; i < PAT_LEN; i++) begin
            if (PAT[i] && !window_i[i]) ones_missing = 1'b1;
            if (!PAT[i] && window_i[i]) zero_errs = zero_errs + 1'b1;
        end
        hit_o = !ones_missing && (int'(zero_errs) <= tol_limit(tol_sel_i));
    end
endmodule

// File: rtl/wake_correlator.sv
`timescale 1ns/1ps
module wake_correlator #(
    parameter int                 CLK_PER_HB = 12,
    parameter int                 IDLE_LIMIT = 108,
    parameter int                 PAT_LEN    = 16,
    parameter logic [PAT_LEN-1:0] PAT        = 16'h9669
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       corr_clr_i,
    input  logic       corr_off_i,
    input  logic [1:0] tol_sel_i,
    input  logic       data_i,
    output logic       match_o,
    output logic       active_o
);
    localparam int FILL_W = $clog2(PAT_LEN + 1);

    typedef struct packed {
        logic               prev;
        logic [PAT_LEN-1:0] hist;
        logic [FILL_W-1:0]  fill;
        logic               match;
    } state_t;

    state_t s_d, s_q;

    logic clear_all, hold, edge_seen;
    logic tick_raw, tick, expire, active, hit;
    logic [PAT_LEN-1:0] window;

    assign clear_all = !en_i || corr_clr_i;
    assign hold      = corr_off_i && !clear_all;
    assign edge_seen = (data_i != s_q.prev);
    assign tick      = tick_raw && active;
    assign window    = {s_q.hist[PAT_LEN-2:0], data_i};

    wkc_halfbit_timer #(.CLK_PER_HB(CLK_PER_HB)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear_all),
        .hold_i  (hold),
        .edge_i  (edge_seen),
        .tick_o  (tick_raw)
    );

    wkc_activity #(.IDLE_LIMIT(IDLE_LIMIT)) u_activity (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (clear_all),
        .hold_i   (hold),
        .edge_i   (edge_seen),
        .active_o (active),
        .expire_o (expire)
    );

    wkc_pattern_scorer #(.PAT_LEN(PAT_LEN), .PAT(PAT)) u_scorer (
        .window_i  (window),
        .tol_sel_i (tol_sel_i),
        .hit_o     (hit)
    );

    always_comb begin
        s_d       = s_q;
        s_d.match = 1'b0;
        if (clear_all) begin
            s_d.prev = data_i;
            s_d.hist = '0;
            s_d.fill = '0;
        end else if (!hold) begin
            s_d.prev = data_i;
            if (expire) begin
                s_d.hist = '0;
                s_d.fill = '0;
            end else if (tick) begin
                s_d.hist = window;
                if (s_q.fill != FILL_W'(PAT_LEN))
                    s_d.fill = s_q.fill + 1'b1;
                s_d.match = hit && (s_q.fill >= FILL_W'(PAT_LEN - 1));
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign match_o  = s_q.match;
    assign active_o = active;
endmodule

// File: rtl/wkc_checker.sv
`timescale 1ns/1ps
module wkc_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic corr_clr_i,
    input logic corr_off_i,
    input logic match_o,
    input logic active_o
);
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> !match_o);

    a_r7_match_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> active_o);

    a_r8_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        corr_clr_i |=> (!active_o && !match_o));

    a_r9_off_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (corr_off_i && en_i && !corr_clr_i) |=> ($stable(active_o) && !match_o));

    a_r10_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!active_o && !match_o));

    always @(negedge clk_i) begin
        if (!rst_ni) a_r11_reset_quiet: assert (!match_o && !active_o);
    end
endmodule

bind wake_correlator wkc_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .corr_clr_i (corr_clr_i),
    .corr_off_i (corr_off_i),
    .match_o    (match_o),
    .active_o   (active_o)
);

// File: tb/wake_correlator_tb.sv
`timescale 1ns/1ps
module wake_correlator_tb;
    logic       clk = 1'b0, rst_n = 1'b0, en = 1'b1, clr = 1'b0, off = 1'b0, data = 1'b0;
    logic [1:0] tol = 2'b01;
    logic       match, active;
    int         total = 0, bad = 0, pulses = 0, p0;

    localparam logic [15:0] PAT = 16'h9669;
    localparam int NV = 10;
    // {tol_sel, 16 half-bits sent first-bit-in-bit-15}
    localparam logic [17:0] VECS [NV] = '{
        {2'b01, 16'h9669}, {2'b11, 16'h9669}, {2'b11, 16'hD669}, {2'b01, 16'hD669},
        {2'b01, 16'hF669}, {2'b10, 16'hF669}, {2'b10, 16'hF66B}, {2'b00, 16'hF66B},
        {2'b00, 16'h9668}, {2'b00, 16'h9669}
    };

    always #5 clk = ~clk;

    wake_correlator u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .corr_clr_i(clr), .corr_off_i(off),
        .tol_sel_i(tol), .data_i(data), .match_o(match), .active_o(active)
    );

    always @(negedge clk) if (match) pulses++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected pulse count for an 8 half-bit preamble followed by p.
    function automatic int model_hits(input logic [15:0] p, input logic [1:0] t);
        logic [23:0] sq;
        logic [15:0] w;
        int n, errs, lim;
        logic ok;
        sq  = {8'hAA, p};
        n   = 0;
        lim = (t == 2'b00) ? 3 : (t == 2'b10) ? 2 : (t == 2'b01) ? 1 : 0;
        for (int j = 0; j <= 8; j++) begin
            w = sq[23-j -: 16];
            ok = 1'b1;
            errs = 0;
            for (int b = 0; b < 16; b++) begin
                if (PAT[b] && !w[b]) ok = 1'b0;
                if (!PAT[b] && w[b]) errs++;
            end
            if (ok && errs <= lim) n++;
        end
        return n;
    endfunction

    task automatic send_hb(input logic b);
        data = b;
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_hb(v[i]);
    endtask

    task automatic settle();
        data = 1'b0;
        repeat (150) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 match in reset", int'(match), 0);
        chk("R11 active in reset", int'(active), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R11 match after reset", int'(match), 0);
        chk("R11 active after reset", int'(active), 0);

        // R2 R3 R4: table of frames and tolerances
        for (int v = 0; v < NV; v++) begin
            tol = VECS[v][17:16];
            p0 = pulses;
            send_bits({8'hAA, VECS[v][15:0]}, 24);
            chk($sformatf("R2 R3 R4 vector %0d", v), pulses - p0,
                model_hits(VECS[v][15:0], VECS[v][17:16]));
            settle();
        end

        // R5: long preamble alone, loosest tolerance
        tol = 2'b00;
        p0 = pulses;
        send_bits(24'hAAAAAA, 24);
        chk("R5 preamble no match", pulses - p0, 0);
        settle();

        // R1 R6: exact pulse cycle
        tol = 2'b11;
        send_bits({9'd0, 8'hAA, PAT[15:1]}, 23);
        p0 = pulses;
        data = PAT[0];
        @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk) chk("R6 no pulse before sample edge", int'(match), 0);
        @(posedge clk);
        @(negedge clk) chk("R1 R6 pulse at sixth edge", int'(match), 1);
        @(posedge clk);
        @(negedge clk) chk("R6 pulse one cycle", int'(match), 0);
        chk("R6 pulse count", pulses - p0, 1);
        @(posedge clk); #1;
        settle();

        // R7: timeout after 108 quiet cycles
        data = 1'b1;
        @(posedge clk);
        @(negedge clk) chk("R7 active on transition", int'(active), 1);
        repeat (107) @(posedge clk);
        @(negedge clk) chk("R7 active at 107 quiet", int'(active), 1);
        @(posedge clk);
        @(negedge clk) chk("R7 idle at 108 quiet", int'(active), 0);
        @(posedge clk); #1;
        settle();

        // R7: frame split by a timeout must not match
        tol = 2'b00;
        p0 = pulses;
        send_bits({9'd0, 8'hAA, PAT[15:9]}, 15);
        repeat (130) @(posedge clk);
        #1;
        chk("R7 idle after gap", int'(active), 0);
        send_bits({15'd0, PAT[8:0]}, 9);
        chk("R7 history emptied", pulses - p0, 0);
        settle();

        // R8: clear on the very sampling edge of the last half-bit
        tol = 2'b11;
        send_bits({9'd0, 8'hAA, PAT[15:1]}, 23);
        p0 = pulses;
        data = PAT[0];
        @(posedge clk);
        repeat (5) @(posedge clk);
        #1 clr = 1'b1;
        @(posedge clk);
        #1 clr = 1'b0;
        @(negedge clk);
        chk("R8 no pulse on clear", int'(match), 0);
        chk("R8 idle after clear", int'(active), 0);
        repeat (20) @(posedge clk);
        #1;
        chk("R8 no late pulse", pulses - p0, 0);
        settle();

        // R9: freeze holds activity past the timeout
        data = 1'b1;
        repeat (10) @(posedge clk);
        #1 off = 1'b1;
        repeat (200) @(posedge clk);
        #1;
        chk("R9 frozen active", int'(active), 1);
        off = 1'b0;
        repeat (120) @(posedge clk);
        #1;
        chk("R9 timeout resumes", int'(active), 0);
        off = 1'b1;
        p0 = pulses;
        send_bits({8'hAA, PAT}, 24);
        chk("R9 no pulse while frozen", pulses - p0, 0);
        chk("R9 idle while frozen", int'(active), 0);
        off = 1'b0;
        settle();

        // R10: disabled channel
        en = 1'b0;
        p0 = pulses;
        send_bits({8'hAA, PAT}, 24);
        chk("R10 no pulse disabled", pulses - p0, 0);
        chk("R10 idle disabled", int'(active), 0);
        en = 1'b1;
        settle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule